// File: doc/BRIEF.md
# Phase-Accumulator Variable Frequency Oscillator

This block is one channel of a numerically controlled oscillator. On every reference clock cycle it adds an increment to a phase register and presents the top bit of that register as a square wave. A companion strobe fires for one cycle on each rising edge of the wave. That strobe is the slow clock enable for a downstream fixed-frequency pulse-width stage. With an effective increment W, the wave runs at W / 65536 of the reference frequency.

Software programs the 16-bit frequency word one byte at a time, using separate write strobes for the upper and lower halves. A word whose top bit is set is not used as it stands: the increment is its 16-bit two's complement. Words from 1 to 32768 are the useful range, and a power-of-two increment gives an exact 50% duty wave.

A new word reaches the accumulator only once both halves have arrived, in either order, so a half-written word never reaches the output. A run enable starts the oscillator from phase zero. Dropping the enable clears the phase and holds it at zero.

Top module: `nco_channel`

## Requirements
- R1: The frequency word is 16 bits; a byte on `wrByte` with `hiWrEn` high loads bits 15:8, and with `loWrEn` high loads bits 7:0.
- R2: The effective increment W equals the word when the word is below 0x8000, and (65536 − word) mod 65536 otherwise (0xC000 gives 0x4000, 0xFF00 gives 0x0100, 0xFFFF gives 1).
- R3: While `runEn` is high, each clock edge adds W to a 16-bit phase modulo 65536; `waveOut` is phase bit 15, so n edges after a start `waveOut` equals bit 15 of (n·W mod 65536).
- R4: A power-of-two W produces a wave that is high for exactly half of every 65536/W-cycle period.
- R5: `tickOut` is high for exactly one cycle in each cycle where `waveOut` has just gone from 0 to 1, and is never high in two consecutive cycles.
- R6: With `runEn` low, the phase is cleared at the next edge and held at zero; `waveOut` and `tickOut` stay low.
- R7: A new word takes effect only when both halves have been written, in either order; the edge that captures the second half commits the word, and the new increment applies from the following edge.
- R8: Writing only one half, with the other half not yet pending, leaves the output following the old increment.
- R9: After reset the word is 0, the phase is 0, no half is pending, and `waveOut` and `tickOut` are low; running with word 0 keeps `waveOut` low.
- R10: Word 0x8000 (W = 32768) makes `waveOut` toggle on every edge while running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Run enable; low clears and holds the phase |
| hiWrEn | input | 1 | Strobe: capture `wrByte` as word bits 15:8 |
| loWrEn | input | 1 | Strobe: capture `wrByte` as word bits 7:0 |
| wrByte | input | 8 | Byte data for the word halves |
| waveOut | output | 1 | Square wave, phase bit 15 |
| tickOut | output | 1 | One-cycle pulse on each rising edge of `waveOut` |

## Verification
The bench builds the block with its default 16-bit word, so the byte halves are 8 bits and full periods stay short for large increments. With words such as 0x4000, 0x0800 and 0x8000, several complete periods fit in a few dozen cycles. Counting high cycles and ticks over whole periods then checks duty and tick rate exactly. Words with the top bit set (0xC000, 0xFF00, 0xFFFF) expose the two's-complement fold. Mid-run writes of single halves, in both orders, show when the increment switches over.

// File: rtl/nco_pkg.sv
package nco_pkg;
  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic commit;    // load the assembled word into the active register
    logic holdZero;  // clear the phase and hold it at zero
  } ncoStrobe_t;
endpackage

// File: rtl/nco_ctrl.sv
module nco_ctrl
  import nco_pkg::*;
#(
  parameter int CW_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              hiWrEn,
  input  logic              loWrEn,
  input  logic [CW_W/2-1:0] wrByte,
  output ncoStrobe_t        strobe,
  output logic [CW_W-1:0]   newWord,
  output logic              pendHi,
  output logic              pendLo
);
  localparam int HALF_W = CW_W / 2;

  logic [HALF_W-1:0] stageHi;
  logic [HALF_W-1:0] stageLo;
  logic              haveHi;
  logic              haveLo;
  logic              commitNow;

  // A half counts as present if it is pending or arriving this cycle
  assign haveHi    = pendHi | hiWrEn;
  assign haveLo    = pendLo | loWrEn;
  assign commitNow = haveHi & haveLo;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageHi <= '0;
      stageLo <= '0;
      pendHi  <= 1'b0;
      pendLo  <= 1'b0;
    end else begin
      if (hiWrEn) stageHi <= wrByte;
      if (loWrEn) stageLo <= wrByte;
      if (commitNow) begin
        pendHi <= 1'b0;
        pendLo <= 1'b0;
      end else begin
        pendHi <= haveHi;
        pendLo <= haveLo;
      end
    end
  end

  always_comb begin
    newWord = {(hiWrEn ? wrByte : stageHi), (loWrEn ? wrByte : stageLo)};
    strobe.commit   = commitNow;
    strobe.holdZero = ~runEn;
  end
endmodule

// File: rtl/nco_datapath.sv
module nco_datapath
  import nco_pkg::*;
#(
  parameter int CW_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  ncoStrobe_t      strobe,
  input  logic [CW_W-1:0] newWord,
  output logic [CW_W-1:0] activeWord,
  output logic            waveOut,
  output logic            tickOut
);
  localparam int MSB = CW_W - 1;

  logic [CW_W-1:0] incr;
  logic [CW_W-1:0] phase;
  logic            prevTop;

  // Words with the top bit set are folded to their two's complement
  always_comb begin
    if (activeWord[MSB]) incr = ~activeWord + {{(CW_W-1){1'b0}}, 1'b1};
    else                 incr = activeWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeWord <= '0;
      phase      <= '0;
      prevTop    <= 1'b0;
    end else begin
      if (strobe.commit) activeWord <= newWord;
      if (strobe.holdZero) begin
        phase   <= '0;
        prevTop <= 1'b0;
      end else begin
        phase   <= phase + incr;
        prevTop <= phase[MSB];
      end
    end
  end

  assign waveOut = phase[MSB];
  assign tickOut = phase[MSB] & ~prevTop;
endmodule

// File: rtl/nco_channel.sv
module nco_channel
  import nco_pkg::*;
#(
  parameter int CW_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              hiWrEn,
  input  logic              loWrEn,
  input  logic [CW_W/2-1:0] wrByte,
  output logic              waveOut,
  output logic              tickOut
);
  ncoStrobe_t      strobe;
  logic [CW_W-1:0] newWord;
  logic [CW_W-1:0] activeWord;
  logic            pendHi;
  logic            pendLo;

  nco_ctrl #(.CW_W(CW_W)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .runEn  (runEn),
    .hiWrEn (hiWrEn),
    .loWrEn (loWrEn),
    .wrByte (wrByte),
    .strobe (strobe),
    .newWord(newWord),
    .pendHi (pendHi),
    .pendLo (pendLo)
  );

  nco_datapath #(.CW_W(CW_W)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .newWord   (newWord),
    .activeWord(activeWord),
    .waveOut   (waveOut),
    .tickOut   (tickOut)
  );
endmodule

// File: rtl/nco_channel_chk.sv
module nco_channel_chk #(
  parameter int CW_W = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            runEn,
  input logic            hiWrEn,
  input logic            loWrEn,
  input logic            waveOut,
  input logic            tickOut,
  input logic            pendHi,
  input logic            pendLo,
  input logic [CW_W-1:0] activeWord
);
  // R5
  tick_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickOut |-> waveOut);

  // R5
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickOut |=> !tickOut);

  // R6
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (!waveOut && !tickOut));

  // R8
  half_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((hiWrEn ^ loWrEn) && !pendHi && !pendLo) |=> $stable(activeWord));

  // R7
  pair_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pendHi || hiWrEn) && (pendLo || loWrEn)) |=> (!pendHi && !pendLo));
endmodule

bind nco_channel nco_channel_chk #(.CW_W(CW_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .runEn     (runEn),
  .hiWrEn    (hiWrEn),
  .loWrEn    (loWrEn),
  .waveOut   (waveOut),
  .tickOut   (tickOut),
  .pendHi    (pendHi),
  .pendLo    (pendLo),
  .activeWord(activeWord)
);

// File: tb/sim_nco_channel.sv
`timescale 1ns/1ps
module sim_nco_channel;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       runEn = 1'b0;
  logic       hiWrEn = 1'b0;
  logic       loWrEn = 1'b0;
  logic [7:0] wrByte = 8'h00;
  logic       waveOut;
  logic       tickOut;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  logic [15:0] phase = '0;
  logic [15:0] wCur = '0;
  logic        prevMsb = 1'b0;
  int          highCnt = 0;
  int          tickCnt = 0;

  always #2.5 clk = ~clk;

  nco_channel u0 (
    .clk(clk), .rstN(rstN), .runEn(runEn), .hiWrEn(hiWrEn),
    .loWrEn(loWrEn), .wrByte(wrByte), .waveOut(waveOut), .tickOut(tickOut)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // Increment from the word, per the fold rule (R2)
  function automatic logic [15:0] effInc(input logic [15:0] cw);
    if (cw < 16'h8000) return cw;
    return 16'(32'h10000 - 32'(cw));
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic checkInt(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One running edge, checked against the phase model (R3, R5)
  task automatic step(input string req);
    logic expMsb;
    logic expTick;
    @(posedge clk);
    phase = phase + wCur;
    @(negedge clk);
    expMsb  = phase[15];
    expTick = expMsb & ~prevMsb;
    check(req, waveOut, expMsb, "wave");
    check(req, tickOut, expTick, "tick");
    if (waveOut) highCnt++;
    if (tickOut) tickCnt++;
    prevMsb = expMsb;
  endtask

  task automatic stopRun();
    runEn = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R6", waveOut, 1'b0, "wave after stop");
    check("R6", tickOut, 1'b0, "tick after stop");
  endtask

  task automatic startRun(input logic [15:0] w);
    runEn = 1'b1;
    phase = '0;
    prevMsb = 1'b0;
    wCur = w;
    highCnt = 0;
    tickCnt = 0;
  endtask

  // Load a whole word while stopped, upper half first (R1)
  task automatic loadWord(input logic [15:0] cw);
    hiWrEn = 1'b1; wrByte = cw[15:8];
    @(posedge clk); @(negedge clk);
    hiWrEn = 1'b0; loWrEn = 1'b1; wrByte = cw[7:0];
    @(posedge clk); @(negedge clk);
    loWrEn = 1'b0;
  endtask

  task automatic runWord(input logic [15:0] cw, input int n, input string req);
    stopRun();
    loadWord(cw);
    startRun(effInc(cw));
    for (int i = 0; i < n; i++) step(req);
  endtask

  task automatic testReset();
    check("R9", waveOut, 1'b0, "wave at reset");
    check("R9", tickOut, 1'b0, "tick at reset");
    startRun(16'h0000);
    for (int i = 0; i < 20; i++) step("R9");
    checkInt("R9", highCnt, 0, "high cycles with word 0");
  endtask

  task automatic testPlain();
    runWord(16'h4000, 32, "R1");
    checkInt("R5", tickCnt, 8, "ticks for W=0x4000 over 32");
    runWord(16'h2AAB, 100, "R3");
  endtask

  task automatic testFold();
    runWord(16'hC000, 32, "R2");
    checkInt("R2", tickCnt, 8, "ticks for word 0xC000");
    runWord(16'hFF00, 300, "R2");
    checkInt("R2", tickCnt, 1, "ticks for word 0xFF00");
    runWord(16'hFFFF, 40, "R2");
    checkInt("R2", highCnt, 0, "high cycles for word 0xFFFF");
  endtask

  task automatic testToggle();
    runWord(16'h8000, 16, "R10");
    checkInt("R10", highCnt, 8, "high cycles for word 0x8000");
    checkInt("R10", tickCnt, 8, "ticks for word 0x8000");
  endtask

  task automatic testDuty();
    runWord(16'h0800, 64, "R4");
    checkInt("R4", highCnt, 32, "high cycles over two periods");
    checkInt("R4", tickCnt, 2, "ticks over two periods");
  endtask

  task automatic testStopHold();
    runWord(16'h4000, 5, "R3");
    stopRun();
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); @(negedge clk);
      check("R6", waveOut, 1'b0, "wave while stopped");
      check("R6", tickOut, 1'b0, "tick while stopped");
    end
  endtask

  task automatic testSplitWrite();
    runWord(16'h4000, 8, "R3");
    // upper half only: old increment must continue
    hiWrEn = 1'b1; wrByte = 8'h08;
    step("R8");
    hiWrEn = 1'b0;
    for (int i = 0; i < 12; i++) step("R8");
    // lower half completes the pair; new word 0x0800 from next edge
    loWrEn = 1'b1; wrByte = 8'h00;
    step("R7");
    loWrEn = 1'b0;
    wCur = effInc(16'h0800);
    for (int i = 0; i < 70; i++) step("R7");
    // lower half first this time
    loWrEn = 1'b1; wrByte = 8'h00;
    step("R8");
    loWrEn = 1'b0;
    for (int i = 0; i < 10; i++) step("R8");
    hiWrEn = 1'b1; wrByte = 8'h20;
    step("R7");
    hiWrEn = 1'b0;
    wCur = effInc(16'h2000);
    for (int i = 0; i < 40; i++) step("R7");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testPlain();
    testFold();
    testToggle();
    testDuty();
    testStopHold();
    testSplitWrite();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule